// File: doc/BRIEF.md
# Display Controller Indexed Register Port

This block is the configuration register file of a display controller. Software reaches it through a small window of four 32-bit I/O offsets. A selector (index) write at offset 0 picks a register number. A data access at offset 1 then reads or writes the register that number selects. Offset 2 is a fixed auxiliary word, and offset 3 reads as all ones. Each register applies its own acceptance rule to writes. Some writes are dropped silently, some are clamped to a set of legal codes, and some have side effects on other state.

The register file holds the following state:
- the controller identity code;
- the enable bit and the configuration-done bit;
- the requested mode width and height;
- the busy flag of the command-queue synchronisation;
- a guest identifier;
- cursor identity, position and visibility;
- a parameterised array of scratch words.

It also answers fixed queries for capabilities, limits and pixel depth. Three one-cycle pulses tell the rest of the display pipeline when to act:
- a mode-change pulse, which also serves as the invalidate request;
- an enable-change pulse;
- a sync-request pulse, which starts a command-queue run.

The queue engine clears busy with `sync_done`.

Every access is a single-cycle strobe (`acc_en`) and is always accepted, so no back-pressure exists on the access side. Read data returns registered one cycle after the strobe, marked by `rd_valid`. Control and status pins are plain levels or one-cycle pulses.

Top module: `dcfg_port`

## Requirements
- R1: Offset 0 writes the selector and reads it back. Offset 2 reads 0x0000CAFE and ignores writes. Offset 3 reads 0xFFFFFFFF. Read data and `rd_valid` appear in the cycle after the strobe.
- R2: The identity register (selector 0) resets to 0x90000002. A write updates it only when the value is 0x90000000, 0x90000001 or 0x90000002.
- R3: A width write (selector 2) is accepted only when the value is at most MAX_W (2368). A height write (selector 3) is accepted only when the value is at most MAX_H (1770). An accepted write pulses `mode_chg`. A rejected write leaves the value unchanged and raises no pulse.
- R4: With a pixel depth of 32, the depth register (6) reads 24. Bits-per-pixel (7) and host bits-per-pixel (28) read 32.
- R5: Writing bits-per-pixel (7) with any value other than 32 clears configuration-done and pulses `mode_chg`. Writing 32 changes nothing.
- R6: The cursor visibility register (27) takes code 1 as show (visibility becomes 1) and code 0 as hide (visibility becomes 0). Codes 2 and 3 leave visibility unchanged.
- R7: Writing the sync register (21) sets busy and pulses `sync_req`. Reads of 21 and 22 return busy. `sync_done` clears busy, but a sync write in the same cycle wins.
- R8: Selectors 1024 to 1791 read zero, ignore writes and raise no `bad_access`.
- R9: Scratch word k sits at selector 1792+k for k below SCRATCH_WORDS (16). Each word can be written and read back. Selector 29 reads SCRATCH_WORDS.
- R10: A data access to an undefined selector, or to one at or beyond 1792+SCRATCH_WORDS, reads zero, ignores writes, and pulses `bad_access` for one cycle.
- R11: After reset the following are all zero: selector, enable, configuration-done, cursor visibility, busy and all pulses.
- R12: Writing the enable register (1) sets enable to (value != 0) and pulses `en_chg`. Writing the configuration-done register (20) sets it to (value != 0).
- R13: The following are read-only and keep their values after writes: maximum width (4) reads MAX_W, maximum height (5) reads MAX_H, capabilities (17) reads CAPS (0x3), and pseudocolour (8) reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one cycle per access |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_port | input | 2 | Window offset 0..3 |
| acc_wdata | input | 32 | Write data |
| sync_done | input | 1 | Queue engine finished, clears busy |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | Read data valid |
| busy | output | 1 | Synchronisation in progress |
| enable | output | 1 | Controller enabled |
| cfg_done | output | 1 | Configuration-done flag |
| scr_width | output | 32 | Requested mode width |
| scr_height | output | 32 | Requested mode height |
| cursor_on | output | 1 | Cursor visibility |
| cursor_x | output | 32 | Cursor X position |
| cursor_y | output | 32 | Cursor Y position |
| mode_chg | output | 1 | Mode changed / invalidate pulse |
| en_chg | output | 1 | Enable written pulse |
| sync_req | output | 1 | Command-queue run request pulse |
| bad_access | output | 1 | Undefined-selector pulse |

## Verification
The bench drives values exactly at and one above each limit (2368/2369 for width, 1770/1771 for height). A design with an off-by-one comparison would either store an illegal mode or reject the largest legal one. It writes a near-miss identity code (0x90000003) and cursor codes 2 and 3. A design that decodes too loosely would corrupt the identity or change cursor visibility. It probes the edges of the palette and scratch ranges (1791, 1792+15, 1792+16) and the gaps in the register numbering. A wrong range compare would alias a scratch word, flag a palette access, or miss a bad access. It also collides `sync_done` with a sync write, where a wrong priority would leave busy low while a queue run is pending.

// File: rtl/dcfg_pkg.sv
package dcfg_pkg;
  typedef enum logic [4:0] {
    RC_ID, RC_ENABLE, RC_WIDTH, RC_HEIGHT, RC_MAXW, RC_MAXH, RC_DEPTH,
    RC_BPP, RC_HBPP, RC_ZERO, RC_CAPS, RC_CFGDONE, RC_SYNC, RC_BUSY,
    RC_GUEST, RC_CURID, RC_CURX, RC_CURY, RC_CURON, RC_SCRCNT,
    RC_SCRATCH, RC_BAD
  } reg_class_e;

  localparam logic [31:0] ID_BASE      = 32'h9000_0000;
  localparam logic [1:0]  PORT_INDEX   = 2'd0;
  localparam logic [1:0]  PORT_VALUE   = 2'd1;
  localparam logic [1:0]  PORT_AUX     = 2'd2;
  localparam logic [31:0] AUX_WORD     = 32'h0000_CAFE;
  localparam int unsigned PAL_FIRST    = 1024;
  localparam int unsigned PAL_LAST     = 1791;
  localparam int unsigned SCR_FIRST    = 1792;
  localparam logic [31:0] CUR_HIDE     = 32'd0;
  localparam logic [31:0] CUR_SHOW     = 32'd1;
endpackage

// File: rtl/dcfg_decode.sv
module dcfg_decode
  import dcfg_pkg::*;
#(
  parameter int unsigned SCRATCH_WORDS = 16,
  localparam int unsigned SLOT_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1
) (
  input  logic [31:0]       sel,
  output reg_class_e        cls,
  output logic [SLOT_W-1:0] slot
);
  logic [31:0] off;

  always_comb begin
    off  = sel - SCR_FIRST;
    slot = off[SLOT_W-1:0];
    unique case (sel)
      32'd0:  cls = RC_ID;
      32'd1:  cls = RC_ENABLE;
      32'd2:  cls = RC_WIDTH;
      32'd3:  cls = RC_HEIGHT;
      32'd4:  cls = RC_MAXW;
      32'd5:  cls = RC_MAXH;
      32'd6:  cls = RC_DEPTH;
      32'd7:  cls = RC_BPP;
      32'd8:  cls = RC_ZERO;
      32'd17: cls = RC_CAPS;
      32'd20: cls = RC_CFGDONE;
      32'd21: cls = RC_SYNC;
      32'd22: cls = RC_BUSY;
      32'd23: cls = RC_GUEST;
      32'd24: cls = RC_CURID;
      32'd25: cls = RC_CURX;
      32'd26: cls = RC_CURY;
      32'd27: cls = RC_CURON;
      32'd28: cls = RC_HBPP;
      32'd29: cls = RC_SCRCNT;
      32'd30, 32'd31, 32'd32: cls = RC_ZERO;
      default: begin
        if (sel >= PAL_FIRST && sel <= PAL_LAST)          cls = RC_ZERO;
        else if (sel >= SCR_FIRST && off < SCRATCH_WORDS) cls = RC_SCRATCH;
        else                                              cls = RC_BAD;
      end
    endcase
  end
endmodule

// File: rtl/dcfg_scratch.sv
module dcfg_scratch #(
  parameter int unsigned WORDS = 16,
  localparam int unsigned SLOT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [SLOT_W-1:0] slot,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata
);
  logic [31:0] word_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)                             word_q[g] <= '0;
      else if (we && slot == SLOT_W'(g))      word_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < WORDS; i++)
      if (slot == SLOT_W'(i)) rdata = word_q[i];
  end
endmodule

// File: rtl/dcfg_core.sv
module dcfg_core
  import dcfg_pkg::*;
#(
  parameter int unsigned MAX_W         = 2368,
  parameter int unsigned MAX_H         = 1770,
  parameter int unsigned PIX_DEPTH     = 32,
  parameter int unsigned SCRATCH_WORDS = 16,
  parameter logic [31:0] CAPS          = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  reg_class_e  cls,
  input  logic [31:0] wdata,
  input  logic [31:0] scr_rdata,
  input  logic        sync_done,
  output logic [31:0] rdata,
  output logic        busy,
  output logic        enable,
  output logic        cfg_done,
  output logic [31:0] width,
  output logic [31:0] height,
  output logic        cursor_on,
  output logic [31:0] cursor_x,
  output logic [31:0] cursor_y,
  output logic        mode_chg,
  output logic        en_chg,
  output logic        sync_req
);
  localparam logic [31:0] DEPTH_W   = 32'(PIX_DEPTH);
  localparam logic [31:0] DEPTH_RD  = (PIX_DEPTH == 32) ? 32'd24 : DEPTH_W;
  localparam logic [31:0] ID_RESET  = ID_BASE | 32'd2;

  logic [31:0] id_q, guest_q, cur_id_q;
  logic        id_ok;

  assign id_ok = (wdata == ID_BASE) || (wdata == (ID_BASE | 32'd1)) ||
                 (wdata == (ID_BASE | 32'd2));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q <= ID_RESET; enable <= 1'b0; cfg_done <= 1'b0; busy <= 1'b0;
      width <= '0; height <= '0; guest_q <= '0; cur_id_q <= '0;
      cursor_on <= 1'b0; cursor_x <= '0; cursor_y <= '0;
      mode_chg <= 1'b0; en_chg <= 1'b0; sync_req <= 1'b0;
    end else begin
      mode_chg <= 1'b0;
      en_chg   <= 1'b0;
      sync_req <= 1'b0;
      if (sync_done) busy <= 1'b0;
      if (wr) begin
        unique case (cls)
          RC_ID:      if (id_ok) id_q <= wdata;
          RC_ENABLE:  begin enable <= |wdata; en_chg <= 1'b1; end
          RC_WIDTH:   if (wdata <= MAX_W) begin width  <= wdata; mode_chg <= 1'b1; end
          RC_HEIGHT:  if (wdata <= MAX_H) begin height <= wdata; mode_chg <= 1'b1; end
          RC_BPP:     if (wdata != 32'd32) begin cfg_done <= 1'b0; mode_chg <= 1'b1; end
          RC_CFGDONE: cfg_done <= |wdata;
          RC_SYNC:    begin busy <= 1'b1; sync_req <= 1'b1; end
          RC_GUEST:   guest_q  <= wdata;
          RC_CURID:   cur_id_q <= wdata;
          RC_CURX:    cursor_x <= wdata;
          RC_CURY:    cursor_y <= wdata;
          RC_CURON: begin
            if (wdata == CUR_SHOW)      cursor_on <= 1'b1;
            else if (wdata == CUR_HIDE) cursor_on <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (cls)
      RC_ID:      rdata = id_q;
      RC_ENABLE:  rdata = {31'b0, enable};
      RC_WIDTH:   rdata = width;
      RC_HEIGHT:  rdata = height;
      RC_MAXW:    rdata = 32'(MAX_W);
      RC_MAXH:    rdata = 32'(MAX_H);
      RC_DEPTH:   rdata = DEPTH_RD;
      RC_BPP,
      RC_HBPP:    rdata = DEPTH_W;
      RC_CAPS:    rdata = CAPS;
      RC_CFGDONE: rdata = {31'b0, cfg_done};
      RC_SYNC,
      RC_BUSY:    rdata = {31'b0, busy};
      RC_GUEST:   rdata = guest_q;
      RC_CURID:   rdata = cur_id_q;
      RC_CURX:    rdata = cursor_x;
      RC_CURY:    rdata = cursor_y;
      RC_CURON:   rdata = {31'b0, cursor_on};
      RC_SCRCNT:  rdata = 32'(SCRATCH_WORDS);
      RC_SCRATCH: rdata = scr_rdata;
      default:    rdata = '0;
    endcase
  end

  p_id_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    id_q[31:2] == ID_BASE[31:2] && id_q[1:0] != 2'd3);
  p_mode_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    width <= MAX_W && height <= MAX_H);
  p_cfg_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cls == RC_BPP && wdata != 32'd32) |=> !cfg_done);
  p_cursor_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cls == RC_CURON && wdata > 32'd1) |=> $stable(cursor_on));
  p_busy_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cls == RC_SYNC) |=> (busy && sync_req));
endmodule

// File: rtl/dcfg_port.sv
module dcfg_port
  import dcfg_pkg::*;
#(
  parameter int unsigned MAX_W         = 2368,
  parameter int unsigned MAX_H         = 1770,
  parameter int unsigned PIX_DEPTH     = 32,
  parameter int unsigned SCRATCH_WORDS = 16,
  parameter logic [31:0] CAPS          = 32'h0000_0003
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_en,
  input  logic        acc_wr,
  input  logic [1:0]  acc_port,
  input  logic [31:0] acc_wdata,
  input  logic        sync_done,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  output logic        busy,
  output logic        enable,
  output logic        cfg_done,
  output logic [31:0] scr_width,
  output logic [31:0] scr_height,
  output logic        cursor_on,
  output logic [31:0] cursor_x,
  output logic [31:0] cursor_y,
  output logic        mode_chg,
  output logic        en_chg,
  output logic        sync_req,
  output logic        bad_access
);
  localparam int unsigned SLOT_W = (SCRATCH_WORDS > 1) ? $clog2(SCRATCH_WORDS) : 1;

  logic [31:0]       sel_q;
  reg_class_e        cls;
  logic [SLOT_W-1:0] slot;
  logic [31:0]       core_rdata, scr_rdata;
  logic              val_acc, val_wr;

  assign val_acc = acc_en && acc_port == PORT_VALUE;
  assign val_wr  = val_acc && acc_wr;

  dcfg_decode #(.SCRATCH_WORDS(SCRATCH_WORDS)) u_dec (
    .sel(sel_q), .cls(cls), .slot(slot));

  dcfg_scratch #(.WORDS(SCRATCH_WORDS)) u_scr (
    .clk(clk), .rst_n(rst_n), .we(val_wr && cls == RC_SCRATCH),
    .slot(slot), .wdata(acc_wdata), .rdata(scr_rdata));

  dcfg_core #(.MAX_W(MAX_W), .MAX_H(MAX_H), .PIX_DEPTH(PIX_DEPTH),
              .SCRATCH_WORDS(SCRATCH_WORDS), .CAPS(CAPS)) u_core (
    .clk(clk), .rst_n(rst_n), .wr(val_wr), .cls(cls), .wdata(acc_wdata),
    .scr_rdata(scr_rdata), .sync_done(sync_done), .rdata(core_rdata),
    .busy(busy), .enable(enable), .cfg_done(cfg_done), .width(scr_width),
    .height(scr_height), .cursor_on(cursor_on), .cursor_x(cursor_x),
    .cursor_y(cursor_y), .mode_chg(mode_chg), .en_chg(en_chg),
    .sync_req(sync_req));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= '0; rd_data <= '0; rd_valid <= 1'b0; bad_access <= 1'b0;
    end else begin
      rd_valid   <= acc_en && !acc_wr;
      bad_access <= val_acc && cls == RC_BAD;
      if (acc_en && acc_wr && acc_port == PORT_INDEX) sel_q <= acc_wdata;
      if (acc_en && !acc_wr) begin
        unique case (acc_port)
          PORT_INDEX: rd_data <= sel_q;
          PORT_VALUE: rd_data <= core_rdata;
          PORT_AUX:   rd_data <= AUX_WORD;
          default:    rd_data <= '1;
        endcase
      end
    end
  end

  p_rd_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(acc_en && !acc_wr));
  p_bad_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(acc_en && acc_port == PORT_VALUE));
endmodule

// File: tb/sim_dcfg_port.sv
module sim_dcfg_port;
  localparam int CLK_PERIOD = 10;
  localparam int MAXW = 2368;
  localparam int MAXH = 1770;

  logic clk = 0, rst_n = 0, acc_en = 0, acc_wr = 0, sync_done = 0;
  logic [1:0] acc_port = 0;
  logic [31:0] acc_wdata = 0;
  logic [31:0] rd_data, scr_width, scr_height, cursor_x, cursor_y;
  logic rd_valid, busy, enable, cfg_done, cursor_on, mode_chg, en_chg, sync_req, bad_access;

  int n_chk = 0, n_fail = 0, cycles = 0;
  logic p_mode, p_en, p_sync, p_bad, p_rdv;

  always #(CLK_PERIOD/2) clk = ~clk;

  dcfg_port u0 (.*);

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  task automatic io(input logic wr, input logic [1:0] port, input logic [31:0] d,
                    output logic [31:0] q);
    @(negedge clk);
    acc_en = 1; acc_wr = wr; acc_port = port; acc_wdata = d;
    @(negedge clk);
    acc_en = 0; acc_wr = 0;
    q = rd_data; p_mode = mode_chg; p_en = en_chg; p_sync = sync_req;
    p_bad = bad_access; p_rdv = rd_valid;
  endtask

  task automatic reg_wr(input logic [31:0] sel, input logic [31:0] d);
    logic [31:0] q;
    io(1, 0, sel, q);
    io(1, 1, d, q);
  endtask

  task automatic reg_rd(input logic [31:0] sel, output logic [31:0] q);
    io(1, 0, sel, q);
    io(0, 1, 0, q);
  endtask

  task automatic t_reset();
    logic [31:0] q;
    chk("R11 enable", {31'b0, enable}, 0);
    chk("R11 cfg_done", {31'b0, cfg_done}, 0);
    chk("R11 cursor_on", {31'b0, cursor_on}, 0);
    chk("R11 busy", {31'b0, busy}, 0);
    chk("R11 pulses", {28'b0, mode_chg, en_chg, sync_req, bad_access}, 0);
    io(0, 0, 0, q);
    chk("R11 selector", q, 0);
    reg_rd(0, q);
    chk("R2 reset id", q, 32'h9000_0002);
  endtask

  task automatic t_window();
    logic [31:0] q;
    io(1, 0, 32'd23, q);
    io(0, 0, 0, q);
    chk("R1 selector readback", q, 23);
    chk("R1 rd_valid", {31'b0, p_rdv}, 1);
    io(1, 2, 32'h1234, q);
    chk("R1 aux write no rd_valid", {31'b0, p_rdv}, 0);
    io(0, 2, 0, q);
    chk("R1 aux read", q, 32'h0000_CAFE);
    io(0, 3, 0, q);
    chk("R1 offset3 read", q, 32'hFFFF_FFFF);
  endtask

  task automatic t_id();
    logic [31:0] q;
    reg_wr(0, 32'h9000_0001); reg_rd(0, q); chk("R2 accept v1", q, 32'h9000_0001);
    reg_wr(0, 32'h9000_0003); reg_rd(0, q); chk("R2 reject near code", q, 32'h9000_0001);
    reg_wr(0, 32'h1234_5678); reg_rd(0, q); chk("R2 reject junk", q, 32'h9000_0001);
    reg_wr(0, 32'h9000_0000); reg_rd(0, q); chk("R2 accept v0", q, 32'h9000_0000);
  endtask

  task automatic t_mode();
    logic [31:0] q;
    reg_wr(2, MAXW);   chk("R3 width max pulse", {31'b0, p_mode}, 1);
    chk("R3 width max", scr_width, MAXW);
    reg_wr(2, MAXW+1); chk("R3 width over no pulse", {31'b0, p_mode}, 0);
    chk("R3 width kept", scr_width, MAXW);
    reg_wr(3, MAXH);   chk("R3 height max", scr_height, MAXH);
    reg_wr(3, MAXH+1); chk("R3 height over no pulse", {31'b0, p_mode}, 0);
    reg_rd(3, q);      chk("R3 height kept", q, MAXH);
    reg_wr(2, 640);    reg_rd(2, q); chk("R3 width 640", q, 640);
  endtask

  task automatic t_depth();
    logic [31:0] q;
    reg_rd(6, q);  chk("R4 depth reads 24", q, 24);
    reg_rd(7, q);  chk("R4 bpp", q, 32);
    reg_rd(28, q); chk("R4 host bpp", q, 32);
  endtask

  task automatic t_enable_cfg();
    logic [31:0] q;
    reg_wr(1, 32'h10); chk("R12 en pulse", {31'b0, p_en}, 1);
    chk("R12 enable set", {31'b0, enable}, 1);
    reg_wr(20, 5);     chk("R12 cfg set", {31'b0, cfg_done}, 1);
    reg_wr(7, 32);     chk("R5 bpp 32 no pulse", {31'b0, p_mode}, 0);
    chk("R5 cfg kept", {31'b0, cfg_done}, 1);
    reg_wr(7, 16);     chk("R5 bpp 16 pulse", {31'b0, p_mode}, 1);
    chk("R5 cfg cleared", {31'b0, cfg_done}, 0);
    reg_rd(20, q);     chk("R5 cfg reg", q, 0);
    reg_wr(1, 0);      chk("R12 enable clear", {31'b0, enable}, 0);
  endtask

  task automatic t_cursor();
    logic [31:0] q;
    reg_wr(25, 77); reg_wr(26, 88);
    chk("R6 cursor x", cursor_x, 77); chk("R6 cursor y", cursor_y, 88);
    reg_wr(27, 1); chk("R6 show", {31'b0, cursor_on}, 1);
    reg_wr(27, 2); chk("R6 code2 keeps", {31'b0, cursor_on}, 1);
    reg_wr(27, 3); chk("R6 code3 keeps", {31'b0, cursor_on}, 1);
    reg_wr(27, 0); chk("R6 hide", {31'b0, cursor_on}, 0);
    reg_wr(27, 3); reg_rd(27, q); chk("R6 code3 keeps hidden", q, 0);
  endtask

  task automatic t_sync();
    logic [31:0] q;
    reg_wr(21, 1); chk("R7 sync pulse", {31'b0, p_sync}, 1);
    chk("R7 busy set", {31'b0, busy}, 1);
    reg_rd(22, q); chk("R7 busy read 22", q, 1);
    @(negedge clk); sync_done = 1; @(negedge clk); sync_done = 0;
    chk("R7 busy cleared", {31'b0, busy}, 0);
    reg_rd(21, q); chk("R7 read 21", q, 0);
    io(1, 0, 21, q);
    @(negedge clk); acc_en = 1; acc_wr = 1; acc_port = 1; acc_wdata = 1; sync_done = 1;
    @(negedge clk); acc_en = 0; acc_wr = 0; sync_done = 0;
    chk("R7 sync wins over done", {31'b0, busy}, 1);
    @(negedge clk); sync_done = 1; @(negedge clk); sync_done = 0;
  endtask

  task automatic t_ranges();
    logic [31:0] q;
    reg_wr(1791, 32'hAAAA); chk("R8 palette no bad", {31'b0, p_bad}, 0);
    reg_rd(1791, q); chk("R8 palette zero", q, 0);
    reg_rd(1024, q); chk("R8 palette first", q, 0);
    reg_wr(1792, 32'h1111_0000); reg_wr(1792+15, 32'h2222_000F);
    reg_rd(1792, q); chk("R9 scratch 0", q, 32'h1111_0000);
    reg_rd(1792+15, q); chk("R9 scratch 15", q, 32'h2222_000F);
    reg_rd(29, q); chk("R9 scratch count", q, 16);
    reg_wr(1792+16, 32'hDEAD); chk("R10 beyond scratch bad", {31'b0, p_bad}, 1);
    reg_rd(1792+16, q); chk("R10 beyond scratch zero", q, 0);
    chk("R10 bad on read", {31'b0, p_bad}, 1);
    reg_rd(1792, q); chk("R10 scratch 0 untouched", q, 32'h1111_0000);
    reg_wr(9, 5); chk("R10 gap bad", {31'b0, p_bad}, 1);
    reg_rd(9, q); chk("R10 gap zero", q, 0);
    reg_rd(2, q); chk("R10 no bad on defined", {31'b0, p_bad}, 0);
  endtask

  task automatic t_readonly();
    logic [31:0] q;
    reg_wr(4, 1); reg_rd(4, q); chk("R13 max width", q, MAXW);
    reg_wr(5, 1); reg_rd(5, q); chk("R13 max height", q, MAXH);
    reg_wr(17, 0); reg_rd(17, q); chk("R13 caps", q, 3);
    reg_wr(8, 9); reg_rd(8, q); chk("R13 pseudocolour", q, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk); cycles++;
      if (cycles > 20000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog: got %0d cycles expected under 20000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_id();
    t_mode();
    t_depth();
    t_enable_cfg();
    t_cursor();
    t_sync();
    t_ranges();
    t_readonly();
    finish_run();
  end
endmodule